// File: doc/BRIEF.md
# Two-Channel Event Timer with Comparators

This block is an event timer mapped into a 32-bit register space. A 64-bit main counter advances by one on each clock while the run bit is set. Two comparator channels watch that counter. Each channel can raise an interrupt once, when the counter equals its comparator. A channel that supports it can instead repeat at a fixed period, with its comparator advanced by a programmed increment after every match. Software uses the register port to read the identification and tick-period words, stop the counter, preset the counter, program the channels, and acknowledge interrupts.

Channel 0 can run periodically. Channel 1 can only fire one-shot. Each channel is programmed through a small state machine with three states:
- `SV_IDLE`: a comparator write loads the match value.
- `SV_LOAD_MATCH`: the set-value sequence is armed and the next low comparator write loads the match value. Transition *arm* enters it from `SV_IDLE`.
- `SV_LOAD_PERIOD`: the next low comparator write loads the period increment. Transition *match loaded* enters it from `SV_LOAD_MATCH`.

Transition *period loaded* returns to `SV_IDLE`. So does transition *abort*, a configuration write with the periodic bit clear, taken from either armed state.

Interrupt status is kept as levels and cleared by writing ones. In normal mode each pending, enabled channel drives the interrupt line named by its route field. In legacy-replacement mode, channel 0 drives a dedicated system-tick output, channel 1 drives a dedicated RTC output, and their route fields are ignored.

Top module: `evt_timer`

## Requirements
- R1: After reset the identification word at 0x000 reads as follows: bits[7:0]=0x01, bits[12:8]=number of channels minus one (1), bit13=1 (64-bit counter) and bit15=1 (legacy replacement supported). The word at 0x004 reads the tick period in femtoseconds (default 69841279). The general configuration at 0x010, the status at 0x020 and the counter all read 0.
- R2: When bit0 (run) of the general configuration at 0x010 is set, the counter advances by one per clock. When run is clear, the counter holds its value, and writes to 0x0F0 (low half) and 0x0F4 (high half) load it. Counter writes made while run is set are ignored.
- R3: The registers of channel n are at 0x100+0x20·n (configuration), 0x108+0x20·n (comparator low) and 0x10C+0x20·n (comparator high). The configuration fields are: bit2 interrupt enable, bit3 periodic, bit6 set-value, bit8 32-bit mode, and bits[13:9] route. Bit4 reads 1 if the channel can run periodically, and bit5 always reads 1.
- R4: A channel with its enable bit set, while the counter runs, matches when the counter equals its comparator. In 32-bit mode only the low 32 bits are compared. Status bit n at 0x020 is set on the clock edge after the match. In one-shot mode the comparator reads back exactly the value last written.
- R5: A configuration write with both periodic and set-value set arms the set-value sequence, and bit6 then reads 1. The next low comparator write loads the match value. The write after that loads the period, and bit6 then reads 0. A high-word write goes to the match or to the period, whichever the sequence is loading.
- R6: In periodic mode the comparator advances by the period on each match. In 32-bit mode the low half wraps modulo 2^32 and the high half is unchanged.
- R7: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. A match in the same cycle as a clear wins, so the bit is set.
- R8: With bit1 (legacy) of the general configuration set, channel 0 drives `tick_irq` and channel 1 drives `rtc_irq`, and neither drives `irq_line`. With legacy clear, `tick_irq` and `rtc_irq` stay low, and a pending, enabled channel drives `irq_line[route]`. A route at or above the line count drives nothing.
- R9: On channel 1 the periodic bit reads 0 and cannot be set, bit4 reads 0, and set-value cannot arm. A comparator write on channel 1 always loads the match value.
- R10: Reads are combinational from `bus_addr`, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | Access is a write when high |
| bus_addr | input | ADDR_W (12) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_line | output | NUM_LINES (8) | Routed interrupt lines, level |
| tick_irq | output | 1 | System-tick interrupt in legacy mode |
| rtc_irq | output | 1 | RTC interrupt in legacy mode |

## Verification
A register write takes effect on the edge that captures it, and reads are due in the same cycle. Once run is set by a write, the counter reads k after k further clock edges. A match at counter value C sets the status bit, and the routed interrupt, on the next edge, so both appear when the counter reads C+1. A periodic comparator shows its advanced value at that same edge. The bench drives inputs and samples outputs only at falling edges, counts the edges between the run write and each check, and compares against counts computed from the programmed comparator and period.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
    localparam int CNT_W  = 64;
    localparam int HALF_W = CNT_W / 2;

    localparam int OFS_ID     = 'h000;
    localparam int OFS_PERIOD = 'h004;
    localparam int OFS_GCFG   = 'h010;
    localparam int OFS_STAT   = 'h020;
    localparam int OFS_CNT_LO = 'h0F0;
    localparam int OFS_CNT_HI = 'h0F4;
    localparam int OFS_CH     = 'h100;
    localparam int CH_STRIDE  = 'h020;
    localparam int CH_CFG     = 'h000;
    localparam int CH_CMP_LO  = 'h008;
    localparam int CH_CMP_HI  = 'h00C;

    localparam int G_RUN = 0;
    localparam int G_LEG = 1;

    localparam int C_IE    = 2;
    localparam int C_PER   = 3;
    localparam int C_PCAP  = 4;
    localparam int C_WCAP  = 5;
    localparam int C_SETV  = 6;
    localparam int C_M32   = 8;
    localparam int C_ROUTE = 9;
    localparam int ROUTE_W = 5;

    typedef enum logic [1:0] {
        SV_IDLE        = 2'd0,
        SV_LOAD_MATCH  = 2'd1,
        SV_LOAD_PERIOD = 2'd2
    } sv_state_e;
endpackage

// File: rtl/evt_counter.sv
module evt_counter
    import evt_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [31:0]       wdata,
    output logic [CNT_W-1:0]  count
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (run) begin
            count <= count + 1'b1;
        end else begin
            if (wr_lo) count[HALF_W-1:0]     <= wdata;
            if (wr_hi) count[CNT_W-1:HALF_W] <= wdata;
        end
    end
endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_timer_pkg::*;
#(
    parameter bit PERIODIC_OK = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   count,
    input  logic               run,
    input  logic               cfg_we,
    input  logic               lo_we,
    input  logic               hi_we,
    input  logic [31:0]        wdata,
    output logic [31:0]        cfg_rd,
    output logic [CNT_W-1:0]   cmp,
    output logic               hit,
    output logic               ie,
    output logic [ROUTE_W-1:0] route,
    output sv_state_e          state
);
    sv_state_e          nxt;
    logic               per_q;
    logic               m32_q;
    logic [CNT_W-1:0]   period_q;
    logic               per_wr;
    logic               to_period;
    logic               setv_rd;

    assign per_wr = PERIODIC_OK && wdata[C_PER];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SV_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            SV_IDLE: begin
                if (cfg_we && per_wr && wdata[C_SETV]) nxt = SV_LOAD_MATCH;  // arm
            end
            SV_LOAD_MATCH: begin
                if (cfg_we && !per_wr) nxt = SV_IDLE;                        // abort
                else if (lo_we)        nxt = SV_LOAD_PERIOD;                 // match loaded
            end
            SV_LOAD_PERIOD: begin
                if ((cfg_we && !per_wr) || lo_we) nxt = SV_IDLE;             // period loaded / abort
            end
            default: nxt = SV_IDLE;
        endcase
    end

    // state-derived outputs
    always_comb begin
        to_period = 1'b0;
        setv_rd   = 1'b0;
        unique case (state)
            SV_IDLE:        ;
            SV_LOAD_MATCH:  setv_rd = 1'b1;
            SV_LOAD_PERIOD: begin
                setv_rd   = 1'b1;
                to_period = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie    <= 1'b0;
            per_q <= 1'b0;
            m32_q <= 1'b0;
            route <= '0;
        end else if (cfg_we) begin
            ie    <= wdata[C_IE];
            per_q <= per_wr;
            m32_q <= wdata[C_M32];
            route <= wdata[C_ROUTE +: ROUTE_W];
        end
    end

    assign hit = run && ie &&
                 (m32_q ? (count[HALF_W-1:0] == cmp[HALF_W-1:0]) : (count == cmp));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp      <= '1;
            period_q <= '0;
        end else if (lo_we || hi_we) begin
            if (lo_we) begin
                if (to_period) period_q[HALF_W-1:0] <= wdata;
                else           cmp[HALF_W-1:0]      <= wdata;
            end
            if (hi_we) begin
                if (to_period) period_q[CNT_W-1:HALF_W] <= wdata;
                else           cmp[CNT_W-1:HALF_W]      <= wdata;
            end
        end else if (hit && per_q) begin
            if (m32_q) cmp[HALF_W-1:0] <= cmp[HALF_W-1:0] + period_q[HALF_W-1:0];
            else       cmp             <= cmp + period_q;
        end
    end

    always_comb begin
        cfg_rd                       = '0;
        cfg_rd[C_IE]                 = ie;
        cfg_rd[C_PER]                = per_q;
        cfg_rd[C_PCAP]               = PERIODIC_OK;
        cfg_rd[C_WCAP]               = 1'b1;
        cfg_rd[C_SETV]               = setv_rd;
        cfg_rd[C_M32]                = m32_q;
        cfg_rd[C_ROUTE +: ROUTE_W]   = route;
    end
endmodule

// File: rtl/evt_irq_route.sv
module evt_irq_route
    import evt_timer_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter int NUM_LINES = 8
) (
    input  logic                            legacy,
    input  logic [NUM_CH-1:0]               act,
    input  logic [NUM_CH-1:0][ROUTE_W-1:0]  route,
    output logic [NUM_LINES-1:0]            irq_line,
    output logic                            tick_irq,
    output logic                            rtc_irq
);
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    always_comb begin
        irq_line = '0;
        tick_irq = 1'b0;
        rtc_irq  = 1'b0;
        for (int n = 0; n < NUM_CH; n++) begin
            if (legacy && n == 0) begin
                tick_irq = act[n];
            end else if (legacy && n == 1) begin
                rtc_irq = act[n];
            end else if (act[n] && (32'(route[n]) < NUM_LINES)) begin
                irq_line[route[n][LINE_W-1:0]] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          NUM_CH    = 2,
    parameter int          NUM_LINES = 8,
    parameter logic [31:0] TICK_FS   = 32'd69841279
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_LINES-1:0] irq_line,
    output logic                 tick_irq,
    output logic                 rtc_irq
);
    localparam logic [31:0] ID_WORD = {16'h0, 1'b1, 1'b0, 1'b1, 5'(NUM_CH - 1), 8'h01};

    logic                           wr_en;
    logic                           run_q;
    logic                           leg_q;
    logic [NUM_CH-1:0]              stat_q;
    logic [CNT_W-1:0]               count;
    logic [NUM_CH-1:0]              hit;
    logic [NUM_CH-1:0]              ie;
    logic [NUM_CH-1:0][ROUTE_W-1:0] route;
    logic [CNT_W-1:0]               ch_cmp [NUM_CH];
    logic [31:0]                    ch_cfg_rd [NUM_CH];
    logic [31:0]                    ch_rd [NUM_CH];
    sv_state_e                      ch_state [NUM_CH];
    logic [31:0]                    fix_rd;

    assign wr_en = bus_valid && bus_write;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            leg_q <= 1'b0;
        end else if (wr_en && bus_addr == ADDR_W'(OFS_GCFG)) begin
            run_q <= bus_wdata[G_RUN];
            leg_q <= bus_wdata[G_LEG];
        end
    end

    evt_counter u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_q),
        .wr_lo (wr_en && bus_addr == ADDR_W'(OFS_CNT_LO)),
        .wr_hi (wr_en && bus_addr == ADDR_W'(OFS_CNT_HI)),
        .wdata (bus_wdata),
        .count (count)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFS_CH + n * CH_STRIDE + CH_CFG);
        localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(OFS_CH + n * CH_STRIDE + CH_CMP_LO);
        localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(OFS_CH + n * CH_STRIDE + CH_CMP_HI);

        evt_channel #(.PERIODIC_OK(n == 0)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .count  (count),
            .run    (run_q),
            .cfg_we (wr_en && bus_addr == A_CFG),
            .lo_we  (wr_en && bus_addr == A_LO),
            .hi_we  (wr_en && bus_addr == A_HI),
            .wdata  (bus_wdata),
            .cfg_rd (ch_cfg_rd[n]),
            .cmp    (ch_cmp[n]),
            .hit    (hit[n]),
            .ie     (ie[n]),
            .route  (route[n]),
            .state  (ch_state[n])
        );

        always_comb begin
            if (bus_addr == A_CFG)     ch_rd[n] = ch_cfg_rd[n];
            else if (bus_addr == A_LO) ch_rd[n] = ch_cmp[n][HALF_W-1:0];
            else if (bus_addr == A_HI) ch_rd[n] = ch_cmp[n][CNT_W-1:HALF_W];
            else                       ch_rd[n] = '0;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                stat_q[n] <= 1'b0;
            else if (hit[n])
                stat_q[n] <= 1'b1;
            else if (wr_en && bus_addr == ADDR_W'(OFS_STAT) && bus_wdata[n])
                stat_q[n] <= 1'b0;
        end
    end

    evt_irq_route #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES)) u_route (
        .legacy   (leg_q),
        .act      (stat_q & ie),
        .route    (route),
        .irq_line (irq_line),
        .tick_irq (tick_irq),
        .rtc_irq  (rtc_irq)
    );

    always_comb begin
        fix_rd = '0;
        case (bus_addr)
            ADDR_W'(OFS_ID):     fix_rd = ID_WORD;
            ADDR_W'(OFS_PERIOD): fix_rd = TICK_FS;
            ADDR_W'(OFS_GCFG):   fix_rd = {30'b0, leg_q, run_q};
            ADDR_W'(OFS_STAT):   fix_rd = 32'(stat_q);
            ADDR_W'(OFS_CNT_LO): fix_rd = count[HALF_W-1:0];
            ADDR_W'(OFS_CNT_HI): fix_rd = count[CNT_W-1:HALF_W];
            default:             fix_rd = '0;
        endcase
    end

    always_comb begin
        bus_rdata = fix_rd;
        for (int n = 0; n < NUM_CH; n++) bus_rdata = bus_rdata | ch_rd[n];
    end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
    import evt_timer_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              run,
    input logic              legacy,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  ch0_cmp,
    input logic              ch0_per,
    input sv_state_e         ch0_state,
    input logic              stat0,
    input logic              tick_irq,
    input logic              rtc_irq
);
    logic wr_cnt;
    logic wr_c0lo;
    logic wr_c0hi;

    assign wr_cnt  = bus_valid && bus_write &&
                     (bus_addr == ADDR_W'(OFS_CNT_LO) || bus_addr == ADDR_W'(OFS_CNT_HI));
    assign wr_c0lo = bus_valid && bus_write && bus_addr == ADDR_W'(OFS_CH + CH_CMP_LO);
    assign wr_c0hi = bus_valid && bus_write && bus_addr == ADDR_W'(OFS_CH + CH_CMP_HI);

    a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_cnt) |=> (count == $past(count)));

    a_r2_step_when_running: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (count == $past(count) + 1'b1));

    a_r4_oneshot_cmp_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch0_per && !wr_c0lo && !wr_c0hi) |=> $stable(ch0_cmp));

    a_r4_status_after_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat0) |-> $past(run && count[HALF_W-1:0] == ch0_cmp[HALF_W-1:0]));

    a_r5_period_write_ends_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_c0lo && ch0_state == SV_LOAD_PERIOD) |=> (ch0_state == SV_IDLE));

    a_r8_legacy_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !legacy |-> (!tick_irq && !rtc_irq));
endmodule

bind evt_timer evt_timer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .run       (run_q),
    .legacy    (leg_q),
    .count     (count),
    .ch0_cmp   (ch_cmp[0]),
    .ch0_per   (ch_cfg_rd[0][evt_timer_pkg::C_PER]),
    .ch0_state (ch_state[0]),
    .stat0     (stat_q[0]),
    .tick_irq  (tick_irq),
    .rtc_irq   (rtc_irq)
);

// File: tb/tb_evt_timer.sv
`timescale 1ns/10ps
module tb_evt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq_line;
    logic        tick_irq;
    logic        rtc_irq;

    int checks = 0;
    int errors = 0;

    evt_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_line(irq_line), .tick_irq(tick_irq), .rtc_irq(rtc_irq)
    );

    always #4 clk = ~clk;

    localparam logic [11:0] A_ID = 12'h000, A_PER = 12'h004, A_GCFG = 12'h010,
                            A_STAT = 12'h020, A_CLO = 12'h0F0, A_CHI = 12'h0F4;

    function automatic logic [11:0] a_cfg(input int n); return 12'(12'h100 + n * 32); endfunction
    function automatic logic [11:0] a_lo(input int n);  return 12'(12'h108 + n * 32); endfunction
    function automatic logic [11:0] a_hi(input int n);  return 12'(12'h10C + n * 32); endfunction
    function automatic logic [31:0] cfg_word(input bit ie, input bit per, input bit setv,
                                             input bit m32, input int rt);
        return (32'(ie) << 2) | (32'(per) << 3) | (32'(setv) << 6) | (32'(m32) << 8) | (32'(rt) << 9);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.2;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8ns * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d, v;
        int c;
        void'($urandom(32'h00C0FFEE));
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        rd(A_ID, d);   chk("R1 id", d, 32'h0000_A101);
        rd(A_PER, d);  chk("R1 period", d, 32'd69841279);
        rd(A_GCFG, d); chk("R1 gcfg", d, 0);
        rd(A_STAT, d); chk("R1 status", d, 0);
        rd(A_CLO, d);  chk("R1 count", d, 0);

        // R10 unmapped read
        rd(12'h040, d); chk("R10 unmapped", d, 0);

        // R3 config fields with capability bits
        wr(a_cfg(0), cfg_word(1, 0, 0, 1, 5));
        rd(a_cfg(0), d); chk("R3 ch0 cfg", d, cfg_word(1, 0, 0, 1, 5) | 32'h30);

        // R9 channel 1 periodic bit locked out
        wr(a_cfg(1), cfg_word(0, 1, 1, 0, 0));
        rd(a_cfg(1), d); chk("R9 ch1 cfg", d, 32'h20);
        wr(a_lo(1), 32'h55);
        rd(a_lo(1), d);  chk("R9 ch1 cmp goes to match", d, 32'h55);

        // R4 random comparator readback, one-shot, counter stopped
        wr(a_cfg(0), 0);
        for (int i = 0; i < 8; i++) begin
            logic [31:0] lo, hi;
            lo = $urandom; hi = $urandom;
            wr(a_lo(0), lo); wr(a_hi(0), hi);
            rd(a_lo(0), d); chk("R4 cmp lo readback", d, lo);
            rd(a_hi(0), d); chk("R4 cmp hi readback", d, hi);
        end

        // R4/R8 one-shot match timing, routed to line 2
        c = 8 + int'($urandom % 32);
        wr(a_cfg(0), cfg_word(1, 0, 0, 1, 2));
        wr(a_lo(0), 32'(c)); wr(a_hi(0), 0);
        wr(A_GCFG, 32'h1);
        tick(c);
        rd(A_STAT, d); chk("R4 no status before match edge", d, 0);
        chk("R8 line idle before", irq_line, 0);
        tick(1);
        rd(A_STAT, d); chk("R4 status after match", d, 1);
        chk("R8 routed line 2", irq_line, 8'h04);
        chk("R8 tick low legacy off", tick_irq, 0);

        // R7 write-one-to-clear
        wr(A_STAT, 32'h2);
        rd(A_STAT, d); chk("R7 zero bit no effect", d, 1);
        wr(A_STAT, 32'h1);
        rd(A_STAT, d); chk("R7 cleared", d, 0);
        chk("R8 line drops", irq_line, 0);

        // R2 counter writes ignored while running
        rd(A_CLO, v);
        wr(A_CLO, 32'hDEAD_BEEF);
        rd(A_CLO, d); chk("R2 write ignored while running", d, v + 2);

        // R2 hold and preset while stopped
        wr(A_GCFG, 0);
        rd(A_CLO, v);
        tick(5);
        rd(A_CLO, d); chk("R2 holds when stopped", d, v);
        wr(A_CLO, 0); wr(A_CHI, 5);
        rd(A_CLO, d); chk("R2 preset lo", d, 0);
        rd(A_CHI, d); chk("R2 preset hi", d, 5);

        // R4 32-bit mode ignores counter high half
        wr(a_cfg(0), cfg_word(1, 0, 0, 1, 2));
        wr(a_lo(0), 20); wr(a_hi(0), 0);
        wr(A_GCFG, 1);
        tick(21);
        rd(A_STAT, d); chk("R4 32-bit match", d, 1);

        // R4 64-bit mode needs the high half
        wr(A_GCFG, 0);
        wr(A_STAT, 3);
        wr(A_CLO, 0); wr(A_CHI, 5);
        wr(a_cfg(0), cfg_word(1, 0, 0, 0, 2));
        wr(A_GCFG, 1);
        tick(30);
        rd(A_STAT, d); chk("R4 64-bit no match", d, 0);

        // R5/R6 set-value sequence and periodic reload
        wr(A_GCFG, 0);
        wr(A_STAT, 3);
        wr(A_CLO, 0); wr(A_CHI, 0);
        wr(a_cfg(0), cfg_word(1, 1, 1, 1, 2));
        rd(a_cfg(0), d); chk("R5 set-value armed", d[6], 1);
        wr(a_lo(0), 10);
        rd(a_cfg(0), d); chk("R5 still armed after match write", d[6], 1);
        wr(a_lo(0), 7);
        rd(a_cfg(0), d); chk("R5 set-value cleared", d[6], 0);
        rd(a_lo(0), d);  chk("R5 match value kept", d, 10);
        wr(A_GCFG, 1);
        tick(11);
        rd(A_STAT, d);   chk("R6 first periodic hit", d, 1);
        rd(a_lo(0), d);  chk("R6 cmp advanced", d, 17);
        wr(A_STAT, 1);
        rd(A_STAT, d);   chk("R7 cleared mid-period", d, 0);
        tick(4);
        rd(A_STAT, d);   chk("R6 no hit before second", d, 0);
        tick(1);
        rd(A_STAT, d);   chk("R6 second periodic hit", d, 1);
        rd(a_lo(0), d);  chk("R6 cmp advanced again", d, 24);

        // R6 32-bit wrap with high half untouched
        wr(A_GCFG, 0);
        wr(A_STAT, 3);
        wr(A_CLO, 32'hFFFF_FFE0); wr(A_CHI, 0);
        wr(a_cfg(0), cfg_word(1, 1, 1, 1, 2));
        wr(a_hi(0), 3);
        wr(a_lo(0), 32'hFFFF_FFF0);
        wr(a_lo(0), 32'h20);
        wr(A_GCFG, 1);
        tick(16);
        rd(A_STAT, d);   chk("R6 no hit before wrap point", d, 0);
        tick(1);
        rd(A_STAT, d);   chk("R6 hit at wrap point", d, 1);
        rd(a_lo(0), d);  chk("R6 low wraps", d, 32'h10);
        rd(a_hi(0), d);  chk("R6 high unchanged", d, 3);

        // R8 legacy replacement routing of channel 1
        wr(A_GCFG, 0);
        wr(a_cfg(0), 0);
        wr(A_STAT, 3);
        wr(A_CLO, 0); wr(A_CHI, 0);
        wr(a_cfg(1), cfg_word(1, 0, 0, 1, 1));
        wr(a_lo(1), 6);
        wr(A_GCFG, 3);
        tick(7);
        chk("R8 rtc in legacy", rtc_irq, 1);
        chk("R8 tick idle in legacy", tick_irq, 0);
        chk("R8 no routed line in legacy", irq_line, 0);
        wr(A_GCFG, 1);
        chk("R8 rtc low legacy off", rtc_irq, 0);
        chk("R8 route 1 legacy off", irq_line, 8'h02);

        // R8 out-of-range route drives nothing
        wr(a_cfg(1), cfg_word(1, 0, 0, 1, 12));
        chk("R8 route beyond lines", irq_line, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule